// File: doc/BRIEF.md
# DMA Channel Address Generator with Pointer Reload

This block produces the source and destination byte addresses for a single DMA channel. Each side keeps two registers: a saved start address and a working pointer. The source and destination sides each have their own stepping mode, either hold, count up or count down. Each also has its own reload point. When the transfer sequencer signals that a byte has moved, the working pointers step by one according to their modes. When a chosen boundary arrives, a pointer is restored from its saved start address. The boundary can be the end of a burst, the end of a block or the end of the whole transaction.

The channel is programmed while idle. A start-address write then sets both the saved copy and the working pointer. The hold mode serves fixed peripheral data registers. The up and down modes walk through memory buffers. Reload lets a repeated block or burst address the same window again, with no reprogramming.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset both `src_addr` and `dst_addr` read 0x0000.
- R2: A start write (`src_wr` / `dst_wr`) while `busy` is low loads both the saved start address and the working pointer of that side, visible on the address output one cycle later. A start write while `busy` is high has no effect on the pointer or on the saved copy.
- R3: With step code 1 (count up), each cycle with `advance` high and no reload makes the pointer the previous value plus one, wrapping from 0xFFFF to 0x0000.
- R4: With step code 2 (count down), each cycle with `advance` high and no reload makes the pointer the previous value minus one, wrapping from 0x0000 to 0xFFFF.
- R5: With step code 0 (hold), `advance` leaves the pointer unchanged. Step code 3 also holds.
- R6: With reload code 1 (burst), a high `burst_end`, `block_end` or `xfer_end` restores the pointer from the saved start address.
- R7: With reload code 2 (block), a high `block_end` or `xfer_end` restores the pointer. `burst_end` alone does not.
- R8: With reload code 3 (transaction), only `xfer_end` restores the pointer.
- R9: With reload code 0 (never), the boundary strobes have no effect on the pointer.
- R10: When a reload and `advance` fall in the same cycle, the pointer takes the saved start address and is not stepped.
- R11: Source and destination use separate step codes, reload codes and saved addresses, and update independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Channel active; start writes are refused while high |
| src_wr | input | 1 | Source start-address write strobe |
| src_start | input | 16 | Source start address |
| dst_wr | input | 1 | Destination start-address write strobe |
| dst_start | input | 16 | Destination start address |
| src_step | input | 2 | Source step code: 0 hold, 1 up, 2 down, 3 hold |
| dst_step | input | 2 | Destination step code |
| src_reload | input | 2 | Source reload code: 0 never, 1 burst, 2 block, 3 transaction |
| dst_reload | input | 2 | Destination reload code |
| advance | input | 1 | One byte transferred |
| burst_end | input | 1 | Burst boundary strobe |
| block_end | input | 1 | Block boundary strobe |
| xfer_end | input | 1 | Transaction boundary strobe |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |

## Verification
The hardest case to reach is a pointer that has stepped far from its saved start and is then reloaded in the same cycle as an advance, through the wider boundary strobes only. An example is a burst-mode side restored by `xfer_end` while the other side steps normally. Random stimulus keeps pointers drifting for long stretches with sparse boundary strobes and occasional mode changes. Directed sequences first walk a pointer away from its start and then fire each strobe against each reload code. Wrap-around is forced by programming 0xFFFF and 0x0000 starts and stepping across them.

// File: rtl/dmaag_pkg.sv
// Shared encodings for the DMA address generator.
// Assumes 2-bit step and reload fields on the top-level ports.
package dmaag_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_UP    = 2'd1,
        STEP_DOWN  = 2'd2,
        STEP_HOLD2 = 2'd3
    } step_mode_e;

    typedef enum logic [1:0] {
        RL_NEVER = 2'd0,
        RL_BURST = 2'd1,
        RL_BLOCK = 2'd2,
        RL_XFER  = 2'd3
    } reload_mode_e;

    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/dmaag_reload_sel.sv
// Decides whether a boundary strobe triggers a reload for one side.
// Wider boundaries imply the narrower ones: a block end is also a burst
// end, and a transaction end is also a block and burst end.
module dmaag_reload_sel
    import dmaag_pkg::*;
(
    input  logic [1:0] reload_sel,
    input  logic       burst_end,
    input  logic       block_end,
    input  logic       xfer_end,
    output logic       reload_hit
);
    logic at_burst;
    logic at_block;

    // Purpose: combine strobes by boundary nesting and pick by reload code.
    always_comb begin
        at_block = block_end | xfer_end;
        at_burst = burst_end | at_block;
        unique case (reload_mode_e'(reload_sel))
            RL_BURST: reload_hit = at_burst;
            RL_BLOCK: reload_hit = at_block;
            RL_XFER:  reload_hit = xfer_end;
            default:  reload_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmaag_pointer.sv
// Saved start address plus working pointer for one side.
// Priority: start load > reload > step. Arithmetic wraps modulo 2^AW.
module dmaag_pointer
    import dmaag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start,
    input  logic [1:0]    step,
    input  logic          reload,
    input  logic          advance,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] saved_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] stepped;
    logic [AW-1:0] ptr_d;

    // Purpose: apply the step mode to the current pointer.
    always_comb begin
        unique case (step_mode_e'(step))
            STEP_UP:   stepped = ptr_q + ONE;
            STEP_DOWN: stepped = ptr_q - ONE;
            default:   stepped = ptr_q;
        endcase
    end

    // Purpose: choose the next pointer by priority.
    always_comb begin
        if (load)         ptr_d = start;
        else if (reload)  ptr_d = saved_q;
        else if (advance) ptr_d = stepped;
        else              ptr_d = ptr_q;
    end

    // Purpose: hold the saved start address.
    always_ff @(posedge clk) begin
        if (!rst_n)    saved_q <= '0;
        else if (load) saved_q <= start;
    end

    // Purpose: hold the working pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign addr = ptr_q;
endmodule

// File: rtl/dmaag_side.sv
// One address side: reload decision feeding a pointer register pair.
// The caller gates the load strobe with channel idle.
module dmaag_side #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start,
    input  logic [1:0]    step,
    input  logic [1:0]    reload_sel,
    input  logic          advance,
    input  logic          burst_end,
    input  logic          block_end,
    input  logic          xfer_end,
    output logic [AW-1:0] addr
);
    logic hit;

    dmaag_reload_sel u_sel (
        .reload_sel (reload_sel),
        .burst_end  (burst_end),
        .block_end  (block_end),
        .xfer_end   (xfer_end),
        .reload_hit (hit)
    );

    dmaag_pointer #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .start   (start),
        .step    (step),
        .reload  (hit),
        .advance (advance),
        .addr    (addr)
    );
endmodule

// File: rtl/dma_addr_gen.sv
// DMA channel address generator: independent source and destination
// pointers with per-side step mode and reload point.
// Assumes the sequencer raises boundary strobes together with the
// advance of the last byte, or on their own cycle.
module dma_addr_gen
    import dmaag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          src_wr,
    input  logic [AW-1:0] src_start,
    input  logic          dst_wr,
    input  logic [AW-1:0] dst_start,
    input  logic [1:0]    src_step,
    input  logic [1:0]    dst_step,
    input  logic [1:0]    src_reload,
    input  logic [1:0]    dst_reload,
    input  logic          advance,
    input  logic          burst_end,
    input  logic          block_end,
    input  logic          xfer_end,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr
);
    logic [NUM_SIDES-1:0]         wr_v;
    logic [NUM_SIDES-1:0][AW-1:0] start_v;
    logic [NUM_SIDES-1:0][1:0]    step_v;
    logic [NUM_SIDES-1:0][1:0]    rl_v;
    logic [NUM_SIDES-1:0][AW-1:0] addr_v;

    // Purpose: gather per-side controls into arrays (0 = source, 1 = destination).
    always_comb begin
        wr_v    = {dst_wr, src_wr};
        start_v = {dst_start, src_start};
        step_v  = {dst_step, src_step};
        rl_v    = {dst_reload, src_reload};
    end

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        dmaag_side #(.AW(AW)) u_side (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (wr_v[g] & ~busy),
            .start      (start_v[g]),
            .step       (step_v[g]),
            .reload_sel (rl_v[g]),
            .advance    (advance),
            .burst_end  (burst_end),
            .block_end  (block_end),
            .xfer_end   (xfer_end),
            .addr       (addr_v[g])
        );
    end

    assign src_addr = addr_v[0];
    assign dst_addr = addr_v[1];
endmodule

// File: rtl/dma_addr_gen_checker.sv
// Port-level temporal checks for dma_addr_gen, bound to every instance.
// Keeps its own shadow of the last accepted source start address.
module dma_addr_gen_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          src_wr,
    input logic [AW-1:0] src_start,
    input logic          dst_wr,
    input logic [AW-1:0] dst_start,
    input logic [1:0]    src_step,
    input logic [1:0]    dst_step,
    input logic [1:0]    src_reload,
    input logic [1:0]    dst_reload,
    input logic          advance,
    input logic          burst_end,
    input logic          block_end,
    input logic          xfer_end,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] dst_addr
);
    logic [AW-1:0] src_shadow;
    logic          src_rl;
    logic          dst_rl;
    logic          src_ld;
    logic          dst_ld;

    // Purpose: reload conditions written from the boundary table.
    always_comb begin
        src_rl = (src_reload == 2'd3 && xfer_end) ||
                 (src_reload == 2'd2 && (xfer_end || block_end)) ||
                 (src_reload == 2'd1 && (xfer_end || block_end || burst_end));
        dst_rl = (dst_reload == 2'd3 && xfer_end) ||
                 (dst_reload == 2'd2 && (xfer_end || block_end)) ||
                 (dst_reload == 2'd1 && (xfer_end || block_end || burst_end));
        src_ld = src_wr && !busy;
        dst_ld = dst_wr && !busy;
    end

    // Purpose: remember the last accepted source start address.
    always_ff @(posedge clk) begin
        if (!rst_n)      src_shadow <= '0;
        else if (src_ld) src_shadow <= src_start;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_ld |=> src_addr == $past(src_start));

    p_busy_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dst_wr && !advance && !dst_rl) |=> $stable(dst_addr));

    p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && src_step == 2'd1 && !src_rl && !src_ld)
        |=> src_addr == $past(src_addr) + AW'(1));

    p_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && dst_step == 2'd2 && !dst_rl && !dst_ld)
        |=> dst_addr == $past(dst_addr) - AW'(1));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_step == 2'd0 || src_step == 2'd3) && !src_rl && !src_ld)
        |=> $stable(src_addr));

    p_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_reload == 2'd0 && !advance && !src_ld) |=> $stable(src_addr));

    p_reload_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rl && !src_ld) |=> src_addr == $past(src_shadow));
endmodule

bind dma_addr_gen dma_addr_gen_checker #(.AW(AW)) u_chk (.*);

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic        src_wr = 1'b0, dst_wr = 1'b0;
    logic [15:0] src_start = '0, dst_start = '0;
    logic [1:0]  src_step = '0, dst_step = '0, src_reload = '0, dst_reload = '0;
    logic        advance = 1'b0, burst_end = 1'b0, block_end = 1'b0, xfer_end = 1'b0;
    logic [15:0] src_addr, dst_addr;

    int total = 0;
    int bad = 0;
    logic [15:0] m_src = '0, m_dst = '0, s_src = '0, s_dst = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_gen uut (.*);

    function automatic logic rl_hit(input logic [1:0] sel, input logic bu,
                                    input logic bl, input logic xe);
        case (sel)
            2'd1:    return bu | bl | xe;
            2'd2:    return bl | xe;
            2'd3:    return xe;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] nxt(input logic [15:0] cur, input logic [15:0] sv,
        input logic ld, input logic [15:0] st, input logic [1:0] stp, input logic hit,
        input logic adv);
        if (ld) return st;
        if (hit) return sv;
        if (adv && stp == 2'd1) return cur + 16'd1;
        if (adv && stp == 2'd2) return cur - 16'd1;
        return cur;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: inputs already set; update model, then compare after edge.
    task automatic tick(input string req);
        logic sl, dl;
        sl = src_wr && !busy;
        dl = dst_wr && !busy;
        @(posedge clk);
        m_src = nxt(m_src, s_src, sl, src_start, src_step,
                    rl_hit(src_reload, burst_end, block_end, xfer_end), advance);
        m_dst = nxt(m_dst, s_dst, dl, dst_start, dst_step,
                    rl_hit(dst_reload, burst_end, block_end, xfer_end), advance);
        if (sl) s_src = src_start;
        if (dl) s_dst = dst_start;
        #1;
        check({req, " src"}, src_addr, m_src);
        check({req, " dst"}, dst_addr, m_dst);
        @(negedge clk);
        src_wr = 0; dst_wr = 0; advance = 0; burst_end = 0; block_end = 0; xfer_end = 0;
    endtask

    task automatic prog(input logic [15:0] s, input logic [15:0] d,
                        input logic [1:0] ss, input logic [1:0] ds,
                        input logic [1:0] sr, input logic [1:0] dr);
        busy = 0; src_wr = 1; dst_wr = 1; src_start = s; dst_start = d;
        src_step = ss; dst_step = ds; src_reload = sr; dst_reload = dr;
        tick("R2");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 src", src_addr, 16'h0000);
        check("R1 dst", dst_addr, 16'h0000);
        rst_n = 1;
        @(negedge clk);

        // R3 wrap up, R4 wrap down, R11 both sides at once
        prog(16'hFFFE, 16'h0001, 2'd1, 2'd2, 2'd0, 2'd0);
        for (int i = 0; i < 3; i++) begin advance = 1; busy = 1; tick("R3 R4 R11"); end
        check("R3 wrap", src_addr, 16'h0001);
        check("R4 wrap", dst_addr, 16'hFFFE);

        // R9 never: boundaries ignored
        burst_end = 1; block_end = 1; xfer_end = 1; tick("R9");

        // R2 busy write ignored, pointer and saved copy
        src_wr = 1; src_start = 16'h5555; tick("R2 busy");
        src_reload = 2'd3; xfer_end = 1; tick("R2 saved copy");
        check("R2 saved kept", src_addr, 16'hFFFE);

        // R5 hold modes
        prog(16'h4000, 16'h8000, 2'd0, 2'd3, 2'd0, 2'd0);
        busy = 1;
        for (int i = 0; i < 3; i++) begin advance = 1; tick("R5"); end
        check("R5 hold", dst_addr, 16'h8000);

        // R7 block: burst alone no reload; R6 burst: block reloads; R10
        prog(16'h1000, 16'h2000, 2'd1, 2'd1, 2'd2, 2'd1);
        busy = 1;
        for (int i = 0; i < 4; i++) begin advance = 1; tick("R3"); end
        advance = 1; burst_end = 1; tick("R6 R7 R10");
        check("R7 burst alone", src_addr, 16'h1005);
        check("R6 burst", dst_addr, 16'h2000);
        advance = 1; block_end = 1; tick("R7 R6 R10");
        check("R7 block", src_addr, 16'h1000);

        // R8 transaction only
        prog(16'h3000, 16'h3000, 2'd2, 2'd2, 2'd3, 2'd2);
        busy = 1;
        advance = 1; tick("R4");
        advance = 1; block_end = 1; tick("R8 R7");
        check("R8 block ignored", src_addr, 16'h2FFE);
        check("R7 block reload", dst_addr, 16'h3000);
        advance = 1; xfer_end = 1; tick("R8 R10");
        check("R8 xfer", src_addr, 16'h3000);
        advance = 1; burst_end = 1; tick("R8 burst ignored");

        // Random mix: R2..R11 against the model
        for (int n = 0; n < 4000; n++) begin
            busy = ($urandom % 8) != 0;
            src_wr = ($urandom % 16) == 0;
            dst_wr = ($urandom % 16) == 0;
            src_start = 16'($urandom);
            dst_start = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
            if ($urandom % 32 == 0) begin
                src_step = 2'($urandom); dst_step = 2'($urandom);
                src_reload = 2'($urandom); dst_reload = 2'($urandom);
            end
            advance = ($urandom % 3) != 0;
            burst_end = ($urandom % 8) == 0;
            block_end = ($urandom % 24) == 0;
            xfer_end = ($urandom % 64) == 0;
            tick("R11 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule